// File: doc/BRIEF.md
# Memory-Card Host Status and Interrupt Aggregator

This block collects one-cycle event pulses from the command engine, data engine, card-detect logic and SDIO logic of a memory-card host controller. It holds them in sticky status bits. Software reads a 32-bit status word and clears individual bits by writing ones. Writing zeros to a bit leaves it as it is. A pulse that lands in the same cycle as a clear of the same bit wins, so no event is lost.

The status word also carries live buffer flags from the data path. These are shown as they are and are never latched. It also carries a 2-bit result code from the write-CRC check, captured whenever a write CRC error is flagged. An enable register selects which sources drive a single registered, level-sensitive interrupt line. A separate group of wake-up enables drives a registered wake line. A combinational error summary output reports any sticky error bit.

Top module: `sdh_evt_agg`

## Requirements
- R1: After reset, every sticky bit, the captured code and the enable register are 0, and `irq_o` and `wake_o` are 0.
- R2: A pulse on `ev_i` at a sticky position sets that status bit at the next clock edge, and the bit stays set until it is cleared. The sticky positions are:
  - 31: card inserted
  - 30: card removed
  - 14: SDIO interrupt
  - 13: command response ended
  - 12: write done
  - 11: read/transfer done
  - 5: response CRC error
  - 3: read CRC error
  - 2: write CRC error
  - 1: response timeout
  - 0: read timeout
- R3: A write with `wr_sel`=0 clears every sticky bit whose `wr_data` bit is 1. Sticky bits whose `wr_data` bit is 0 keep their value.
- R4: When a pulse and a clearing write hit the same sticky bit in the same cycle, the bit is set afterwards.
- R5: Status bits 6 (write-ready, `buf_i[0]`), 7 (read-ready, `buf_i[1]`) and 24..29 (`buf_i[7:2]`: overflow, underrun, X-full, Y-full, X-empty, Y-empty) follow `buf_i` in the same cycle. Status writes do not affect them.
- R6: Status bits [10:9] hold the value of `wcrc_code_i` captured on the last write-CRC-error pulse (`ev_i[2]`). The value 2 means no CRC token was returned. Pulses on other bits do not change the code, and status writes do not clear it.
- R7: A write with `wr_sel`=1 loads the enable register through the mask 0x0007_F01F. With `rd_sel`=1, `rd_data` returns the enable register, and bits outside the mask read 0.
- R8: `irq_o` rises one edge after the status bit of an enabled source is set, and falls one edge after that source goes away. The enable-to-source pairs are:
  - 0: bit 11
  - 1: bit 12
  - 2: bit 13
  - 3: write-ready
  - 4: read-ready
  - 12: `dat0_i`
  - 13: bit 14
  - 14: bit 30
  - 15: bit 31
  A set source whose enable is 0 leaves `irq_o` at 0.
- R9: `wake_o` is driven one edge later from the wake-up enables. The pairs are:
  - 16: bit 30
  - 17: bit 31
  - 18: bit 14
  The wake-up enables are independent of the interrupt enables.
- R10: `err_any_o` is 1 exactly while any sticky bit in mask 0x2F is set.
- R11: Pulses on `ev_i` positions outside the sticky set have no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 32 | One-cycle event pulses, bit-aligned to status |
| wcrc_code_i | input | 2 | Write-CRC result code, valid with `ev_i[2]` |
| buf_i | input | 8 | Live buffer flags |
| dat0_i | input | 1 | DAT0 line level for its interrupt source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (clear), 1 enables |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 status, 1 enables |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Registered interrupt level |
| wake_o | output | 1 | Registered wake-up level |
| err_any_o | output | 1 | Any sticky error bit set |

## Verification
A sticky bit or captured code is due in the status word one edge after its pulse or clear. `irq_o` and `wake_o` are due one edge after that. `rd_data` live flags and `err_any_o` are due in the same cycle as their cause. The driver changes inputs just after a rising edge and queues each expected item together with the falling edge at which it is due. The monitor compares at that falling edge, so the interrupt and wake checks confirm both the quiet cycle and the asserted cycle that follows.

// File: rtl/sdh_evt_pkg.sv
package sdh_evt_pkg;
    localparam int DW     = 32;
    localparam int CODE_W = 2;
    localparam int BUF_W  = 8;
    localparam int N_IRQ  = 9;
    localparam int N_WAKE = 3;

    localparam logic [DW-1:0] STICKY_MASK = 32'hC000_782F;
    localparam logic [DW-1:0] ERR_MASK    = 32'h0000_002F;
    localparam logic [DW-1:0] EN_MASK     = 32'h0007_F01F;
    localparam logic [DW-1:0] IRQ_EN_MASK = 32'h0000_F01F;
    localparam logic [DW-1:0] WK_EN_MASK  = 32'h0007_0000;

    localparam int ST_INS     = 31;
    localparam int ST_REM     = 30;
    localparam int ST_SDIO    = 14;
    localparam int ST_CMDEND  = 13;
    localparam int ST_WRDONE  = 12;
    localparam int ST_RDDONE  = 11;
    localparam int CODE_LSB   = 9;
    localparam int ST_WCRC    = 2;
    localparam int ST_WRRDY   = 6;
    localparam int ST_RDRDY   = 7;
    localparam int ST_BUF_LSB = 24;

    localparam int EN_RDOP  = 0;
    localparam int EN_WROP  = 1;
    localparam int EN_CMD   = 2;
    localparam int EN_BUFWR = 3;
    localparam int EN_BUFRD = 4;
    localparam int EN_DAT0  = 12;
    localparam int EN_SDIO  = 13;
    localparam int EN_REM   = 14;
    localparam int EN_INS   = 15;
    localparam int WK_REM   = 16;
    localparam int WK_INS   = 17;
    localparam int WK_SDIO  = 18;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d;

    // A set in the same cycle as a clear keeps the bit high.
    always_comb begin
        q_d = ((q_o & ~clr_i) | set_i) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= q_d;
    end
endmodule

// File: rtl/sdh_code_cap.sv
module sdh_code_cap #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_o <= '0;
        else if (cap_i) code_o <= code_i;
    end
endmodule

// File: rtl/sdh_irq_comb.sv
module sdh_irq_comb #(
    parameter int N_IRQ  = 9,
    parameter int N_WAKE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_src_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    input  logic [N_WAKE-1:0] wk_src_i,
    input  logic [N_WAKE-1:0] wk_en_i,
    output logic              irq_o,
    output logic              wake_o
);
    logic [N_IRQ-1:0]  irq_hit;
    logic [N_WAKE-1:0] wk_hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq_hit[i] = irq_src_i[i] & irq_en_i[i];
    end
    for (genvar j = 0; j < N_WAKE; j++) begin : g_wk
        assign wk_hit[j] = wk_src_i[j] & wk_en_i[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |irq_hit;
            wake_o <= |wk_hit;
        end
    end
endmodule

// File: rtl/sdh_evt_agg.sv
module sdh_evt_agg
    import sdh_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     ev_i,
    input  logic [CODE_W-1:0] wcrc_code_i,
    input  logic [BUF_W-1:0]  buf_i,
    input  logic              dat0_i,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_sel,
    output logic [DW-1:0]     rd_data,
    output logic              irq_o,
    output logic              wake_o,
    output logic              err_any_o
);
    logic [DW-1:0]     sticky_q;
    logic [DW-1:0]     clr_vec;
    logic [DW-1:0]     en_q;
    logic [DW-1:0]     live_word;
    logic [DW-1:0]     status_word;
    logic [CODE_W-1:0] code_q;
    logic [N_IRQ-1:0]  irq_src, irq_en;
    logic [N_WAKE-1:0] wk_src, wk_en;

    assign clr_vec = (wr_en && (wr_sel == SEL_STATUS)) ? wr_data : '0;

    sdh_sticky_bank #(.W(DW), .MASK(STICKY_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_i),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    sdh_code_cap #(.W(CODE_W)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (ev_i[ST_WCRC]),
        .code_i (wcrc_code_i),
        .code_o (code_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              en_q <= '0;
        else if (wr_en && (wr_sel == SEL_ENABLE)) en_q <= wr_data & EN_MASK;
    end

    always_comb begin
        live_word = '0;
        live_word[ST_WRRDY] = buf_i[0];
        live_word[ST_RDRDY] = buf_i[1];
        live_word[ST_BUF_LSB +: BUF_W-2] = buf_i[BUF_W-1:2];
        status_word = sticky_q | live_word;
        status_word[CODE_LSB +: CODE_W] = code_q;
    end

    assign rd_data   = (rd_sel == SEL_ENABLE) ? en_q : status_word;
    assign err_any_o = |(sticky_q & ERR_MASK);

    assign irq_src = {sticky_q[ST_INS], sticky_q[ST_REM], sticky_q[ST_SDIO], dat0_i,
                      buf_i[1], buf_i[0], sticky_q[ST_CMDEND], sticky_q[ST_WRDONE],
                      sticky_q[ST_RDDONE]};
    assign irq_en  = {en_q[EN_INS], en_q[EN_REM], en_q[EN_SDIO], en_q[EN_DAT0],
                      en_q[EN_BUFRD], en_q[EN_BUFWR], en_q[EN_CMD], en_q[EN_WROP],
                      en_q[EN_RDOP]};
    assign wk_src  = {sticky_q[ST_SDIO], sticky_q[ST_INS], sticky_q[ST_REM]};
    assign wk_en   = {en_q[WK_SDIO], en_q[WK_INS], en_q[WK_REM]};

    sdh_irq_comb #(.N_IRQ(N_IRQ), .N_WAKE(N_WAKE)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src_i (irq_src),
        .irq_en_i  (irq_en),
        .wk_src_i  (wk_src),
        .wk_en_i   (wk_en),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );
endmodule

// File: rtl/sdh_evt_agg_chk.sv
module sdh_evt_agg_chk
    import sdh_evt_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] ev_i,
    input logic [DW-1:0] sticky_q,
    input logic [DW-1:0] en_q,
    input logic          irq_o,
    input logic          wake_o
);
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(ev_i & STICKY_MASK)) == $past(ev_i & STICKY_MASK))); // R2

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 1'b0) |=> ((sticky_q & $past(wr_data & ~ev_i)) == '0)); // R3

    AST_NO_SPONTANEOUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 1'b0 && |(ev_i & wr_data & STICKY_MASK))
        |=> ((sticky_q & $past(ev_i & wr_data & STICKY_MASK)) != '0)); // R4

    AST_EN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~EN_MASK) == '0); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(en_q & IRQ_EN_MASK))); // R8

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(|(en_q & WK_EN_MASK))); // R9
endmodule

bind sdh_evt_agg sdh_evt_agg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ev_i     (ev_i),
    .sticky_q (sticky_q),
    .en_q     (en_q),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
);

// File: tb/test_sdh_evt_agg.sv
module test_sdh_evt_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ev_i;
    logic [1:0]  wcrc_code_i;
    logic [7:0]  buf_i;
    logic        dat0_i;
    logic        wr_en, wr_sel;
    logic [31:0] wr_data;
    logic        rd_sel;
    logic [31:0] rd_data;
    logic        irq_o, wake_o, err_any_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        logic        sel;
        logic [31:0] data;
        logic        irq;
        logic        wake;
        logic        err;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    sdh_evt_agg i_sdh_evt_agg (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wcrc_code_i(wcrc_code_i),
        .buf_i(buf_i), .dat0_i(dat0_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_o(irq_o), .wake_o(wake_o), .err_any_o(err_any_o)
    );

    // Monitor: pops one expected item at each falling edge and compares.
    initial begin
        item_t it;
        rd_sel = 1'b0;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                rd_sel = it.sel;
                #1;
                n_chk++;
                if (rd_data !== it.data || irq_o !== it.irq ||
                    wake_o !== it.wake || err_any_o !== it.err) begin
                    n_bad++;
                    $display("FAIL %s: data=%h exp=%h irq=%b exp=%b wake=%b exp=%b err=%b exp=%b",
                             it.req, rd_data, it.data, irq_o, it.irq, wake_o, it.wake,
                             err_any_o, it.err);
                end
            end
        end
    end

    task automatic expect_now(string req, logic sel, logic [31:0] d,
                              logic irq, logic wake, logic err);
        item_t it;
        it.req = req; it.sel = sel; it.data = d;
        it.irq = irq; it.wake = wake; it.err = err;
        sb.push_back(it);
        @(negedge clk);
        #3;
    endtask

    task automatic pulse(logic [31:0] v, logic [1:0] code);
        @(posedge clk); #1;
        ev_i = v; wcrc_code_i = code;
        @(posedge clk); #1;
        ev_i = '0;
    endtask

    task automatic reg_wr(logic sel, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse_and_clear(logic [31:0] v, logic [31:0] d);
        @(posedge clk); #1;
        ev_i = v; wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
        @(posedge clk); #1;
        ev_i = '0; wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ev_i = '0; wcrc_code_i = '0; buf_i = '0; dat0_i = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_now("R1 status", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        expect_now("R1 enables", 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);

        // R7 enable mask
        reg_wr(1'b1, 32'hFFFF_FFFF);
        expect_now("R7 enable mask", 1'b1, 32'h0007_F01F, 1'b0, 1'b0, 1'b0);
        reg_wr(1'b1, 32'h0);
        idle(1);

        // R2 sticky set
        pulse(32'h8000_2000, 2'd0);
        expect_now("R2 set", 1'b0, 32'h8000_2000, 1'b0, 1'b0, 1'b0);
        idle(2);
        expect_now("R2 held", 1'b0, 32'h8000_2000, 1'b0, 1'b0, 1'b0);

        // R11 non-sticky positions ignored
        pulse(32'h0000_0110, 2'd0);
        expect_now("R11 ignored", 1'b0, 32'h8000_2000, 1'b0, 1'b0, 1'b0);

        // R3 write-one-to-clear, zeros keep
        reg_wr(1'b0, 32'h0000_2000);
        expect_now("R3 clear one", 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        reg_wr(1'b0, 32'h0);
        expect_now("R3 zero keeps", 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0);

        // R4 set wins over clear
        pulse_and_clear(32'h0000_2000, 32'h0000_2000);
        expect_now("R4 set beats clear", 1'b0, 32'h8000_2000, 1'b0, 1'b0, 1'b0);
        reg_wr(1'b0, 32'hFFFF_FFFF);
        expect_now("R3 clear all", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

        // R10 error summary
        pulse(32'h0000_0021, 2'd0);
        expect_now("R10 err set", 1'b0, 32'h0000_0021, 1'b0, 1'b0, 1'b1);
        reg_wr(1'b0, 32'h0000_0021);
        expect_now("R10 err cleared", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

        // R5 live flags
        buf_i = 8'hFF;
        expect_now("R5 live all", 1'b0, 32'h3F00_00C0, 1'b0, 1'b0, 1'b0);
        reg_wr(1'b0, 32'hFFFF_FFFF);
        expect_now("R5 write no effect", 1'b0, 32'h3F00_00C0, 1'b0, 1'b0, 1'b0);
        buf_i = 8'h06;
        expect_now("R5 live mix", 1'b0, 32'h0100_0080, 1'b0, 1'b0, 1'b0);
        buf_i = 8'h00;

        // R8 interrupt timing: insertion source
        reg_wr(1'b1, 32'h0000_8000);
        pulse(32'h8000_0000, 2'd0);
        expect_now("R8 irq quiet cycle", 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        expect_now("R8 irq rises", 1'b0, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
        reg_wr(1'b0, 32'h8000_0000);
        expect_now("R8 irq lags clear", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
        expect_now("R8 irq falls", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

        // R8 disabled source keeps irq low
        pulse(32'h4000_0000, 2'd0);
        idle(1);
        expect_now("R8 disabled source", 1'b0, 32'h4000_0000, 1'b0, 1'b0, 1'b0);
        reg_wr(1'b0, 32'h4000_0000);

        // R8 live write-ready source
        reg_wr(1'b1, 32'h0000_0008);
        @(posedge clk); #1;
        buf_i = 8'h01;
        expect_now("R8 bufwr quiet", 1'b0, 32'h0000_0040, 1'b0, 1'b0, 1'b0);
        expect_now("R8 bufwr irq", 1'b0, 32'h0000_0040, 1'b1, 1'b0, 1'b0);
        buf_i = 8'h00;
        idle(2);

        // R8 DAT0 source
        reg_wr(1'b1, 32'h0000_1000);
        @(posedge clk); #1;
        dat0_i = 1'b1;
        expect_now("R8 dat0 quiet", 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        expect_now("R8 dat0 irq", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
        dat0_i = 1'b0;
        idle(2);

        // R9 wake from insertion, separate from irq enables
        reg_wr(1'b1, 32'h0002_0000);
        pulse(32'h8000_0000, 2'd0);
        expect_now("R9 wake quiet", 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
        expect_now("R9 wake rises", 1'b0, 32'h8000_0000, 1'b0, 1'b1, 1'b0);
        reg_wr(1'b0, 32'hFFFF_FFFF);
        reg_wr(1'b1, 32'h0);
        idle(2);

        // R6 write-CRC code capture
        pulse(32'h0000_0004, 2'd2);
        expect_now("R6 code no token", 1'b0, 32'h0000_0404, 1'b0, 1'b0, 1'b1);
        pulse(32'h0000_0001, 2'd3);
        expect_now("R6 code held", 1'b0, 32'h0000_0405, 1'b0, 1'b0, 1'b1);
        reg_wr(1'b0, 32'hFFFF_FFFF);
        expect_now("R6 code survives clear", 1'b0, 32'h0000_0400, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule